// File: doc/BRIEF.md
# Supply-Fault and Watchdog Reset Supervisor

This block produces the processor reset for a supply monitor. Four external comparators each report whether the supply sits below one of four trip levels. A two-bit selector chooses which of those flags counts as a fault. The reset output is an open-drain pin modelled as a drive-enable: when it is high, the pad pulls the line low. When it is low, the line is released, so other reset sources can share the wire. Reset goes active in the same cycle that the selected flag asserts. After the flag clears, reset stays active for a fixed number of 1 kHz ticks. With the default of 100 ticks, that is 100 ms.

A free-running watchdog counts the same tick. Its timeout is set in steps of `WD_STEP_TICKS` ticks by a 5-bit field, and a value of zero switches it off. A restart pulse clears its count. When the watchdog expires it starts the same reset-and-hold sequence. A status bit records whether the last reset came from the watchdog, and a clear pulse resets that bit.

While reset is active, the serial bus interface is disabled and new memory operations are refused. An operation that was already granted before the fault keeps its grant until the requester drops it.

Top module: `pwr_fail_supervisor`

## Requirements
- R1: After the synchronous reset `rst_n` is released, `rst_oe` is 1 and `bus_en` is 0. Both stay that way until `HOLD_TICKS` ticks with no fault have passed, and then the reset is released. `wd_cause` reads 0 after reset.
- R2: The fault condition is `below_trip[trip_sel]`, where code 00 is the lowest level (2.6 V), 01 is 2.9 V, 10 is 3.9 V and 11 is 4.4 V. When it is 1, `rst_oe` is 1 in the same cycle. Flags that `trip_sel` does not select have no effect on `rst_oe`.
- R3: After the fault clears, `rst_oe` stays 1 through `HOLD_TICKS-1` ticks and drops to 0 after the `HOLD_TICKS`-th tick. If the fault returns during that count, the count starts over.
- R4: `rst_oe` is a drive-enable only, where 1 means pull the reset line low. The block has no output that drives the line high.
- R5: While `rst_oe` is 1, `bus_en` is 0 and a newly raised `mem_req` does not receive `mem_grant`.
- R6: A `mem_req` that was granted while `rst_oe` was 0 keeps `mem_grant` at 1 through a following fault, for as long as `mem_req` stays high.
- R7: When `wd_period` is nonzero and no restart occurs, the watchdog expires on tick number `wd_period*WD_STEP_TICKS` counted after reset was released. That expiry sets `rst_oe` to 1, and the reset is then held as in R3.
- R8: When `wd_period` is 0, the watchdog never causes a reset.
- R9: A one-cycle `wd_kick` pulse clears the watchdog count, so a full timeout must elapse again before the watchdog expires.
- R10: A watchdog expiry sets `wd_cause` to 1. A supply fault or a `cause_clr` pulse sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1k | input | 1 | One-cycle pulse at 1 kHz |
| below_trip | input | 4 | Per-level below-threshold flags, indexed by level code |
| trip_sel | input | 2 | Selected trip level code |
| wd_period | input | 5 | Watchdog timeout in steps; 0 turns the watchdog off |
| wd_kick | input | 1 | Watchdog restart pulse |
| cause_clr | input | 1 | Clears the watchdog-cause status bit |
| mem_req | input | 1 | Memory operation request, held for the length of the operation |
| rst_oe | output | 1 | Reset pad drive-enable (1 = pull low) |
| bus_en | output | 1 | Serial bus interface enable |
| mem_grant | output | 1 | Memory operation permitted |
| wd_cause | output | 1 | 1 = last reset came from the watchdog |

## Verification
The assertions assume that `tick_1k` is a single-cycle pulse that never lasts two consecutive cycles. They also assume that `trip_sel` and `wd_period` change only while no count that depends on them is in progress. The bench produces ticks only through a task that drives one high cycle followed by one low cycle. It changes the configuration inputs only while reset is being held or before a new count starts. Restart and clear pulses last exactly one cycle and fall on cycles with no tick.

// File: rtl/supv_pkg.sv
// Package: shared constants and types for the reset supervisor.
// Assumes four trip levels addressed by a two-bit code.
package supv_pkg;
    localparam int LEVELS = 4;
    localparam int SEL_W  = $clog2(LEVELS);

    typedef enum logic {
        CAUSE_SUPPLY = 1'b0,
        CAUSE_WDOG   = 1'b1
    } cause_e;
endpackage

// File: rtl/supv_trip_mux.sv
// Module: chooses the below-threshold flag that belongs to the selected
// trip level. Assumes the comparator flags are already synchronous to clk.
module supv_trip_mux
    import supv_pkg::*;
(
    input  logic [LEVELS-1:0] below_trip,
    input  logic [SEL_W-1:0]  trip_sel,
    output logic              fault
);
    // Purpose: one-hot decode of the selector, then AND-OR the flags.
    logic [LEVELS-1:0] hit;
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign hit[g] = below_trip[g] && (trip_sel == SEL_W'(g));
    end
    assign fault = |hit;
endmodule

// File: rtl/supv_hold_ctrl.sv
// Module: holds reset active while a fault is present and for HOLD_TICKS
// ticks after the fault clears or after a watchdog expiry. It also records
// what caused the last reset. Assumes tick is a single-cycle pulse.
module supv_hold_ctrl
    import supv_pkg::*;
#(
    parameter int HOLD_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fault,
    input  logic wd_expire,
    input  logic cause_clr,
    output logic rst_act,
    output logic wd_cause
);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam logic [HOLD_W-1:0] LAST = HOLD_W'(HOLD_TICKS - 1);

    logic [HOLD_W-1:0] hold_cnt;
    cause_e            cause_q;

    // Purpose: start or restart the hold on any event; release after the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_act  <= 1'b1;
            hold_cnt <= '0;
        end else if (fault || wd_expire) begin
            rst_act  <= 1'b1;
            hold_cnt <= '0;
        end else if (rst_act && tick) begin
            if (hold_cnt == LAST) begin
                rst_act  <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // Purpose: record the reset cause; events take priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         cause_q <= CAUSE_SUPPLY;
        else if (fault)     cause_q <= CAUSE_SUPPLY;
        else if (wd_expire) cause_q <= CAUSE_WDOG;
        else if (cause_clr) cause_q <= CAUSE_SUPPLY;
    end

    assign wd_cause = (cause_q == CAUSE_WDOG);

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> rst_act); // R2
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_act) |-> ($past(hold_cnt) == LAST && $past(tick) && !$past(fault))); // R3
    AST_CAUSE_FROM_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_cause) |-> $past(wd_expire)); // R10
endmodule

// File: rtl/supv_watchdog.sv
// Module: free-running watchdog that counts ticks up to period*STEP_TICKS.
// It stays cleared while reset is held, while it is disabled (period 0)
// and on a restart pulse. Assumes tick is a single-cycle pulse.
module supv_watchdog #(
    parameter int PER_W      = 5,
    parameter int STEP_TICKS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic             kick,
    input  logic             hold,
    output logic             expire
);
    localparam int WD_W = $clog2(((1 << PER_W) - 1) * STEP_TICKS + 1);
    localparam logic [WD_W-1:0] STEP_V = WD_W'(STEP_TICKS);

    logic [WD_W-1:0] cnt;
    logic [WD_W-1:0] limit;
    logic            enabled;

    // Purpose: derive the terminal count from the programmed period.
    always_comb begin
        limit   = WD_W'(period) * STEP_V;
        enabled = (period != '0);
        expire  = tick && enabled && !hold && !kick && (cnt == limit - 1'b1);
    end

    // Purpose: advance on ticks, clear on restart, hold, disable or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || kick || !enabled) cnt <= '0;
        else if (expire)                        cnt <= '0;
        else if (tick)                          cnt <= cnt + 1'b1;
    end

    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0)); // R9
    AST_OFF_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |=> (cnt == '0)); // R8
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |-> (cnt < limit)); // R7
endmodule

// File: rtl/supv_bus_gate.sv
// Module: locks out the serial bus and new memory operations while reset
// is active. A request that was granted earlier keeps its grant until the
// requester drops it. Assumes mem_req stays high for a whole operation.
module supv_bus_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic lock,
    input  logic mem_req,
    output logic bus_en,
    output logic mem_grant
);
    logic op_live;

    // Purpose: remember an operation that was admitted while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) op_live <= 1'b0;
        else        op_live <= mem_req && (op_live || !lock);
    end

    assign bus_en    = !lock;
    assign mem_grant = mem_req && (op_live || !lock);

    AST_ADMIT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_live) |-> !$past(lock)); // R5
    AST_LIVE_KEEPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_live && mem_req) |-> mem_grant); // R6
endmodule

// File: rtl/pwr_fail_supervisor.sv
// Module: top of the supply-fault and watchdog reset supervisor.
// It selects the trip flag, holds the reset, runs the watchdog and gates
// bus access. Assumes all inputs are synchronous to clk.
module pwr_fail_supervisor
    import supv_pkg::*;
#(
    parameter int HOLD_TICKS    = 100,
    parameter int WD_STEP_TICKS = 100,
    parameter int WD_PER_W      = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_1k,
    input  logic [LEVELS-1:0]   below_trip,
    input  logic [SEL_W-1:0]    trip_sel,
    input  logic [WD_PER_W-1:0] wd_period,
    input  logic                wd_kick,
    input  logic                cause_clr,
    input  logic                mem_req,
    output logic                rst_oe,
    output logic                bus_en,
    output logic                mem_grant,
    output logic                wd_cause
);
    logic fault;
    logic rst_act;
    logic wd_expire;

    supv_trip_mux u_mux (
        .below_trip (below_trip),
        .trip_sel   (trip_sel),
        .fault      (fault)
    );

    supv_hold_ctrl #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1k),
        .fault     (fault),
        .wd_expire (wd_expire),
        .cause_clr (cause_clr),
        .rst_act   (rst_act),
        .wd_cause  (wd_cause)
    );

    supv_watchdog #(.PER_W(WD_PER_W), .STEP_TICKS(WD_STEP_TICKS)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1k),
        .period (wd_period),
        .kick   (wd_kick),
        .hold   (rst_act),
        .expire (wd_expire)
    );

    // Purpose: pull the pad low immediately on a fault and throughout the hold.
    assign rst_oe = rst_act || fault;

    supv_bus_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (rst_oe),
        .mem_req   (mem_req),
        .bus_en    (bus_en),
        .mem_grant (mem_grant)
    );

    AST_WDOG_ASSERTS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> rst_oe); // R7
    AST_LOCK_DURING_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_oe |-> !bus_en); // R5
endmodule

// File: tb/tb_pwr_fail_supervisor.sv
// Directed bench: one task per scenario. Inputs are driven on the falling
// edge and outputs are sampled on the falling edge.
module tb_pwr_fail_supervisor;
    localparam int HOLD = 10;
    localparam int STEP = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1k = 1'b0;
    logic [3:0] below_trip = '0;
    logic [1:0] trip_sel = 2'd0;
    logic [4:0] wd_period = '0;
    logic       wd_kick = 1'b0;
    logic       cause_clr = 1'b0;
    logic       mem_req = 1'b0;
    logic       rst_oe, bus_en, mem_grant, wd_cause;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwr_fail_supervisor #(.HOLD_TICKS(HOLD), .WD_STEP_TICKS(STEP), .WD_PER_W(5)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .below_trip(below_trip),
        .trip_sel(trip_sel), .wd_period(wd_period), .wd_kick(wd_kick),
        .cause_clr(cause_clr), .mem_req(mem_req), .rst_oe(rst_oe),
        .bus_en(bus_en), .mem_grant(mem_grant), .wd_cause(wd_cause)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_1k = 1'b1;
            @(negedge clk) tick_1k = 1'b0;
        end
    endtask

    task automatic pulse_kick();
        @(negedge clk) wd_kick = 1'b1;
        @(negedge clk) wd_kick = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 rst_oe after reset", rst_oe, 1'b1);
        check("R1 bus_en after reset", bus_en, 1'b0);
        check("R1 wd_cause after reset", wd_cause, 1'b0);
        ticks(HOLD - 1);
        check("R1 still held", rst_oe, 1'b1);
        ticks(1);
        check("R1 released", rst_oe, 1'b0);
        check("R1 bus_en released", bus_en, 1'b1);
    endtask

    task automatic t_trip_select();
        @(negedge clk) trip_sel = 2'd2; below_trip = 4'b1011;
        #1 check("R2 unselected flags ignored", rst_oe, 1'b0);
        below_trip = 4'b0100;
        #1 check("R2 selected flag same cycle", rst_oe, 1'b1);
        check("R4 drive-enable asserted", rst_oe, 1'b1);
        @(negedge clk) below_trip = 4'b0000;
        ticks(HOLD);
        check("R2 released after hold", rst_oe, 1'b0);
        @(negedge clk) trip_sel = 2'd0; below_trip = 4'b0001;
        #1 check("R2 level 00 flag", rst_oe, 1'b1);
        @(negedge clk) below_trip = 4'b0000;
    endtask

    task automatic t_hold_restart();
        ticks(5);
        @(negedge clk) below_trip = 4'b0001;
        @(negedge clk) below_trip = 4'b0000;
        ticks(HOLD - 1);
        check("R3 restart keeps reset", rst_oe, 1'b1);
        ticks(1);
        check("R3 release after full hold", rst_oe, 1'b0);
    endtask

    task automatic t_lockout();
        @(negedge clk) mem_req = 1'b1;
        @(negedge clk) check("R6 grant before fault", mem_grant, 1'b1);
        below_trip = 4'b0001;
        #1 check("R6 in-flight keeps grant", mem_grant, 1'b1);
        check("R5 bus locked", bus_en, 1'b0);
        @(negedge clk) check("R6 grant held in fault", mem_grant, 1'b1);
        mem_req = 1'b0;
        @(negedge clk) mem_req = 1'b1;
        #1 check("R5 new request refused", mem_grant, 1'b0);
        @(negedge clk) check("R5 still refused", mem_grant, 1'b0);
        mem_req = 1'b0; below_trip = 4'b0000;
        ticks(HOLD);
        check("R5 bus back", bus_en, 1'b1);
    endtask

    task automatic t_watchdog();
        @(negedge clk) wd_period = 5'd2;
        ticks(2 * STEP - 1);
        check("R7 no early expiry", rst_oe, 1'b0);
        ticks(1);
        check("R7 expiry asserts reset", rst_oe, 1'b1);
        check("R10 cause set by watchdog", wd_cause, 1'b1);
        ticks(HOLD);
        check("R7 hold after expiry", rst_oe, 1'b0);
        ticks(2 * STEP - 2);
        pulse_kick();
        ticks(2 * STEP - 1);
        check("R9 kick restarts count", rst_oe, 1'b0);
        ticks(1);
        check("R9 expiry after full period", rst_oe, 1'b1);
        @(negedge clk) cause_clr = 1'b1;
        @(negedge clk) cause_clr = 1'b0;
        check("R10 clear pulse", wd_cause, 1'b0);
        ticks(HOLD);
        ticks(2 * STEP);
        check("R10 second expiry", wd_cause, 1'b1);
        @(negedge clk) wd_period = 5'd0; below_trip = 4'b0001;
        @(negedge clk) below_trip = 4'b0000;
        check("R10 supply fault clears cause", wd_cause, 1'b0);
        ticks(HOLD);
        ticks(40 * STEP);
        check("R8 disabled watchdog", rst_oe, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_trip_select();
        t_hold_restart();
        t_lockout();
        t_watchdog();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule